// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block provides the message-passing interrupts for a two-port shared memory. The two highest word addresses serve as mailboxes. The top address belongs to port 1, and the address one below it belongs to port 0. When one port writes the other port's mailbox, the owner's interrupt line goes active. The line is released when the owner reads its own mailbox.

The two mailbox words are held in local registers and are returned combinationally on reads. General storage and arbitration sit outside this block. Each port has a hold input, driven by the arbiter, that reports the port has lost a contended access. While hold is high, that port can neither raise the other port's interrupt nor clear its own.

Top module: `mbox_irq`

## Requirements
- R1: After reset both interrupt outputs are high (inactive) and both mailbox words read as zero.
- R2: Port 0's mailbox is at address 2^AW-2 and port 1's is at 2^AW-1. An accepted write by either port to either mailbox is stored. While a port's sel and rd are high, its rdata shows the addressed mailbox word, or zero for any other address and whenever sel or rd is low. Writes to other addresses change nothing.
- R3: An accepted port 0 write to 2^AW-1 drives p1_irq_n low from the next cycle. An accepted port 1 write to 2^AW-2 drives p0_irq_n low from the next cycle.
- R4: An accepted read by a port of its own mailbox drives that port's irq_n high from the next cycle.
- R5: Reading the other port's mailbox, or writing one's own mailbox, leaves both interrupt outputs unchanged.
- R6: While a port's hold is high, its write is ignored: no mailbox word changes and no interrupt is raised.
- R7: While a port's hold is high, its read of its own mailbox returns the word but does not clear its interrupt.
- R8: If a set and a clear of the same interrupt fall in one cycle, the interrupt ends up set.
- R9: If both ports write the same mailbox in one cycle, port 0's data is stored.
- R10: An access needs sel high. With wr and rd both high it counts as a write only and cannot clear an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_sel | input | 1 | Port 0 access select |
| p0_wr | input | 1 | Port 0 write strobe |
| p0_rd | input | 1 | Port 0 read strobe |
| p0_hold | input | 1 | Port 0 lost arbitration |
| p0_addr | input | AW | Port 0 word address |
| p0_wdata | input | DW | Port 0 write data |
| p0_rdata | output | DW | Port 0 mailbox read data |
| p0_irq_n | output | 1 | Port 0 interrupt, active low |
| p1_sel | input | 1 | Port 1 access select |
| p1_wr | input | 1 | Port 1 write strobe |
| p1_rd | input | 1 | Port 1 read strobe |
| p1_hold | input | 1 | Port 1 lost arbitration |
| p1_addr | input | AW | Port 1 word address |
| p1_wdata | input | DW | Port 1 write data |
| p1_rdata | output | DW | Port 1 mailbox read data |
| p1_irq_n | output | 1 | Port 1 interrupt, active low |

## Verification
The internal state is two flag bits and two data words. A wrong flag appears on an irq_n pin in the cycle after the access that caused it, so the checks sample the interrupts one edge after every access. A wrong mailbox word shows only when a port next reads that mailbox. For this reason, every address is written by each port and then read back at once by the opposite port. Hold, same-cycle conflicts and strobe combinations are each followed directly by an interrupt check and a read.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p0_sel,
  input  logic          p0_wr,
  input  logic          p0_rd,
  input  logic          p0_hold,
  input  logic [AW-1:0] p0_addr,
  input  logic [DW-1:0] p0_wdata,
  output logic [DW-1:0] p0_rdata,
  output logic          p0_irq_n,
  input  logic          p1_sel,
  input  logic          p1_wr,
  input  logic          p1_rd,
  input  logic          p1_hold,
  input  logic [AW-1:0] p1_addr,
  input  logic [DW-1:0] p1_wdata,
  output logic [DW-1:0] p1_rdata,
  output logic          p1_irq_n
);
  localparam logic [AW-1:0] BOX1 = '1;
  localparam logic [AW-1:0] BOX0 = BOX1 - 1'b1;

  logic [DW-1:0] box0, box1;
  logic          flag0, flag1;

  wire wr0 = p0_sel & p0_wr & ~p0_hold;
  wire wr1 = p1_sel & p1_wr & ~p1_hold;
  wire rd0 = p0_sel & p0_rd & ~p0_wr & ~p0_hold;
  wire rd1 = p1_sel & p1_rd & ~p1_wr & ~p1_hold;

  wire set0 = wr1 & (p1_addr == BOX0);
  wire set1 = wr0 & (p0_addr == BOX1);
  wire clr0 = rd0 & (p0_addr == BOX0);
  wire clr1 = rd1 & (p1_addr == BOX1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      box0  <= '0;
      box1  <= '0;
      flag0 <= 1'b0;
      flag1 <= 1'b0;
    end else begin
      if (wr0 && p0_addr == BOX0)      box0 <= p0_wdata;
      else if (wr1 && p1_addr == BOX0) box0 <= p1_wdata;
      if (wr0 && p0_addr == BOX1)      box1 <= p0_wdata;
      else if (wr1 && p1_addr == BOX1) box1 <= p1_wdata;
      if (set0)      flag0 <= 1'b1;
      else if (clr0) flag0 <= 1'b0;
      if (set1)      flag1 <= 1'b1;
      else if (clr1) flag1 <= 1'b0;
    end
  end

  assign p0_irq_n = ~flag0;
  assign p1_irq_n = ~flag1;

  assign p0_rdata = !(p0_sel && p0_rd) ? '0 :
                    (p0_addr == BOX0) ? box0 :
                    (p0_addr == BOX1) ? box1 : '0;
  assign p1_rdata = !(p1_sel && p1_rd) ? '0 :
                    (p1_addr == BOX0) ? box0 :
                    (p1_addr == BOX1) ? box1 : '0;

  a_r3_set0: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_sel && p1_wr && !p1_hold && p1_addr == BOX0) |=> !p0_irq_n);
  a_r3_set1: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_sel && p0_wr && !p0_hold && p0_addr == BOX1) |=> !p1_irq_n);
  a_r4_clr0: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_sel && p0_rd && !p0_wr && !p0_hold && p0_addr == BOX0 &&
     !(p1_sel && p1_wr && !p1_hold && p1_addr == BOX0)) |=> p0_irq_n);
  a_r4_clr1: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_sel && p1_rd && !p1_wr && !p1_hold && p1_addr == BOX1 &&
     !(p0_sel && p0_wr && !p0_hold && p0_addr == BOX1)) |=> p1_irq_n);
  a_r6_hold0: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_hold && !(p1_sel && p1_wr && !p1_hold && p1_addr == BOX1) &&
     !(p1_sel && p1_rd && !p1_wr && !p1_hold && p1_addr == BOX1)) |=> $stable(p1_irq_n));
  a_r7_hold1: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_hold && !(p0_sel && p0_wr && !p0_hold && p0_addr == BOX1) && p1_irq_n == 1'b0)
    |=> !p1_irq_n);
endmodule

// File: tb/test_mbox_irq.sv
module test_mbox_irq;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int B1 = (1 << AW) - 1;
  localparam int B0 = B1 - 1;

  logic clk = 0, rst_n = 0;
  logic p0_sel = 0, p0_wr = 0, p0_rd = 0, p0_hold = 0;
  logic p1_sel = 0, p1_wr = 0, p1_rd = 0, p1_hold = 0;
  logic [AW-1:0] p0_addr = '0, p1_addr = '0;
  logic [DW-1:0] p0_wdata = '0, p1_wdata = '0;
  logic [DW-1:0] p0_rdata, p1_rdata;
  logic p0_irq_n, p1_irq_n;

  int checks = 0, errors = 0;
  logic [DW-1:0] m0 = 0, m1 = 0;
  logic f0 = 0, f1 = 0;

  always #2 clk = ~clk;

  mbox_irq #(.AW(AW), .DW(DW)) i_mbox_irq (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rexp(logic s, logic r, int a);
    if (!(s && r)) return 0;
    if (a == B0) return m0;
    if (a == B1) return m1;
    return 0;
  endfunction

  task automatic step(string req,
      logic s0, logic w0, logic r0, logic h0, int a0, int d0,
      logic s1, logic w1, logic r1, logic h1, int a1, int d1);
    logic aw0, aw1, ar0, ar1, st0, st1, cl0, cl1;
    p0_sel = s0; p0_wr = w0; p0_rd = r0; p0_hold = h0; p0_addr = a0[AW-1:0]; p0_wdata = d0[DW-1:0];
    p1_sel = s1; p1_wr = w1; p1_rd = r1; p1_hold = h1; p1_addr = a1[AW-1:0]; p1_wdata = d1[DW-1:0];
    #1;
    check({req, " rdata0"}, int'(p0_rdata), rexp(s0, r0, a0));
    check({req, " rdata1"}, int'(p1_rdata), rexp(s1, r1, a1));
    aw0 = s0 && w0 && !h0;  aw1 = s1 && w1 && !h1;
    ar0 = s0 && r0 && !w0 && !h0;  ar1 = s1 && r1 && !w1 && !h1;
    st0 = aw1 && a1 == B0;  st1 = aw0 && a0 == B1;
    cl0 = ar0 && a0 == B0;  cl1 = ar1 && a1 == B1;
    if (aw0 && a0 == B0) m0 = d0[DW-1:0]; else if (aw1 && a1 == B0) m0 = d1[DW-1:0];
    if (aw0 && a0 == B1) m1 = d0[DW-1:0]; else if (aw1 && a1 == B1) m1 = d1[DW-1:0];
    f0 = st0 ? 1'b1 : cl0 ? 1'b0 : f0;
    f1 = st1 ? 1'b1 : cl1 ? 1'b0 : f1;
    @(posedge clk); #1;
    check({req, " irq0"}, int'(p0_irq_n), int'(!f0));
    check({req, " irq1"}, int'(p1_irq_n), int'(!f1));
    p0_sel = 0; p0_wr = 0; p0_rd = 0; p0_hold = 0;
    p1_sel = 0; p1_wr = 0; p1_rd = 0; p1_hold = 0;
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1 irq0", int'(p0_irq_n), 1);
    check("R1 irq1", int'(p1_irq_n), 1);
    step("R1", 1,0,1,0,B0,0, 1,0,1,0,B1,0);
    // R2 R3 R4 sweep: each port writes every address, other port reads it back
    for (int p = 0; p < 2; p++)
      for (int a = 0; a <= B1; a++) begin
        if (p == 0) begin
          step("R2 R3 wr", 1,1,0,0,a,a*7+1, 0,0,0,0,0,0);
          step("R2 R5 rd", 0,0,0,0,0,0, 1,0,1,0,a,0);
        end else begin
          step("R2 R3 wr", 0,0,0,0,0,0, 1,1,0,0,a,a*5+3);
          step("R2 R5 rd", 1,0,1,0,a,0, 0,0,0,0,0,0);
        end
        step("R4 clr", 1,0,1,0,B0,0, 1,0,1,0,B1,0);
      end
    // R5 cross reads and own-mailbox writes
    step("R3", 0,0,0,0,0,0, 1,1,0,0,B0,8'h5a);
    step("R5 other read", 0,0,0,0,0,0, 1,0,1,0,B0,0);
    step("R5 own write", 1,1,0,0,B0,8'h11, 1,1,0,0,B1,8'h22);
    // R7 hold blocks clear
    step("R7 hold read", 1,0,1,1,B0,0, 0,0,0,0,0,0);
    step("R4", 1,0,1,0,B0,0, 0,0,0,0,0,0);
    // R6 hold blocks write
    step("R6 hold write", 1,1,0,1,B1,8'h99, 1,1,0,1,B0,8'h77);
    step("R6 readback", 1,0,1,0,B1,0, 1,0,1,0,B0,0);
    // R8 set and clear together
    step("R3", 0,0,0,0,0,0, 1,1,0,0,B0,8'h33);
    step("R8 set wins", 1,0,1,0,B0,0, 1,1,0,0,B0,8'h44);
    step("R4", 1,0,1,0,B0,0, 0,0,0,0,0,0);
    // R9 both write same mailbox
    step("R9 same box", 1,1,0,0,B1,8'hc3, 1,1,0,0,B1,8'h3c);
    step("R9 readback", 1,0,1,0,B1,0, 1,0,1,0,B1,0);
    // R10 sel low and wr+rd together
    step("R10 no sel", 0,1,0,0,B1,8'he1, 0,1,0,0,B0,8'he2);
    step("R10 wr rd", 1,1,1,0,B0,8'h6b, 1,1,1,0,B1,8'h6c);
    step("R10 readback", 1,0,1,0,B1,0, 1,0,1,0,B0,0);
    step("R4", 1,0,1,0,B0,0, 1,0,1,0,B1,0);
    // R1 reset again
    rst_n = 0;
    @(posedge clk); #1;
    rst_n = 1; m0 = 0; m1 = 0; f0 = 0; f1 = 0;
    check("R1 irq0 rst", int'(p0_irq_n), 1);
    check("R1 irq1 rst", int'(p1_irq_n), 1);
    step("R1 rst read", 1,0,1,0,B1,0, 1,0,1,0,B0,0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule